// File: doc/BRIEF.md
# Character Display Command Engine

This block sits behind the host bus of a character display module. It interprets the byte stream the host writes, which is split into instruction bytes and data bytes by a register-select bit. It keeps the state the display runs from: the address counter, the entry direction and auto-shift flag, the display, cursor and blink enables, the horizontal shift offset, the one-line or two-line setting and the brightness code. Data bytes become write strobes to an external display-data RAM or to an external character-generator RAM. The last set-address instruction decides which of the two RAMs a data byte goes to.

Each accepted byte makes the engine busy for a fixed number of cycles, and the engine ignores host bytes while it is busy. A clear instruction writes the blank code 20h to every display-data location, one location per cycle, and the engine stays busy until the last location is written. A free-running four-step phase counter turns the 2-bit brightness code into a pulse-width enable for the anode drivers. In one-line mode the enable for the upper anode half is held low.

Top module: `chardisp_cmd_engine`

## Requirements
- R1: After reset, busy is low, the address counter and the shift offset are 0, the display, cursor and blink are off, two-line mode is selected, the brightness code is 00, the entry mode is increment without shift, data goes to display-data RAM, and no write strobe or anode enable is high.
- R2: An instruction byte is decoded by its highest set bit: 01h clear, 02h-03h home, 04h-07h entry mode (bit1 = 1 increment, bit0 = 1 auto-shift), 08h-0Fh display control (bit2 display on, bit1 cursor on, bit0 blink on), 10h-1Fh cursor/display shift, 20h-3Fh function set (bit3 = 1 two-line, bits1:0 brightness), 40h-7Fh set character-generator address (bits5:0), 80h-FFh set display-data address (bits6:0).
- R3: A data byte aimed at display-data RAM is written at the current address counter with one strobe cycle, and then the counter steps +1 or -1 by the entry mode, wrapping modulo 128.
- R4: A data byte aimed at character-generator RAM is written at the low 6 bits of the address counter with only data bits 4:0 kept, and then the counter steps +1 or -1, wrapping modulo 64.
- R5: Data bytes go to character-generator RAM after a set character-generator address instruction and to display-data RAM after a set display-data address instruction, until the next such instruction.
- R6: Shift instruction bits 3:2 select: 00 address counter -1, 01 address counter +1, 10 shift offset +1 (display moves left), 11 shift offset -1 (display moves right). A display shift leaves the address counter unchanged.
- R7: With auto-shift on, each display-data write also moves the shift offset: +1 in increment mode, -1 in decrement mode.
- R8: Clear writes 20h to all 128 display-data locations, sets the address counter and shift offset to 0, selects increment mode and display-data RAM, and keeps busy high for exactly 128 cycles after the accepting edge.
- R9: Every other accepted byte keeps busy high for BUSY_CYC (default 4) cycles. Bytes presented while busy is high are ignored.
- R10: With the display on, the lower anode enable is high for 4, 3, 2 or 1 of every 4 cycles for brightness codes 00, 01, 10 and 11.
- R11: In one-line mode (function set bit3 = 0) the upper anode enable stays low. In two-line mode it follows the lower enable.
- R12: With the display off, both anode enables stay low.
- R13: Return home sets the address counter and the shift offset to 0 and leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host byte present this cycle |
| cmd_rs | input | 1 | 1 = data byte, 0 = instruction byte |
| cmd_byte | input | 8 | Host byte |
| busy | output | 1 | Engine busy, host bytes ignored |
| ac_out | output | 7 | Address counter |
| dd_we | output | 1 | Display-data RAM write strobe |
| dd_addr | output | 7 | Display-data RAM address |
| dd_wdata | output | 8 | Display-data RAM write data |
| cg_we | output | 1 | Character-generator RAM write strobe |
| cg_addr | output | 6 | Character-generator RAM address |
| cg_wdata | output | 5 | Character-generator RAM pixel row |
| disp_on | output | 1 | Display enable |
| cursor_on | output | 1 | Cursor enable |
| blink_on | output | 1 | Cursor blink enable |
| shift_ofs | output | 7 | Display shift offset |
| one_line | output | 1 | One-line mode selected |
| bright | output | 2 | Brightness code |
| anode_lo_en | output | 1 | Pulse-width enable, lower anode half |
| anode_hi_en | output | 1 | Pulse-width enable, upper anode half |

## Verification
A wrong address counter shows on ac_out at the first sample after the accepting edge. It also misplaces the next write strobe, so the bench's RAM model, built from the strobes, differs at a known location. A wrong RAM-target flag or entry flag shows on the next data byte as a strobe on the wrong RAM or a step in the wrong direction. Errors in the busy timer or the fill pointer change the busy pulse length and the count of blank writes. Errors in the brightness decode show as a wrong count of enabled cycles in any 8-cycle window, within a few cycles of the function set.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;

  // Decoded host operations
  typedef enum logic [3:0] {
    OP_NONE,
    OP_CLEAR,
    OP_HOME,
    OP_ENTRY,
    OP_DISPCTL,
    OP_SHIFT,
    OP_FUNC,
    OP_SET_CG,
    OP_SET_DD,
    OP_WRITE
  } cde_op_e;

  // Shift instruction selector, bits 3:2 of the byte
  typedef enum logic [1:0] {
    SH_CUR_LEFT  = 2'b00,
    SH_CUR_RIGHT = 2'b01,
    SH_DISP_LEFT = 2'b10,
    SH_DISP_RIGHT= 2'b11
  } cde_shift_e;

  localparam logic [7:0] BLANK_CODE = 8'h20;

endpackage

// File: rtl/cde_decode.sv
module cde_decode
  import chardisp_pkg::*;
(
  input  logic       is_data,
  input  logic [7:0] byte_in,
  output cde_op_e    op
);

  // Priority on the highest set bit of an instruction byte
  always_comb begin
    op = OP_NONE;
    if (is_data)            op = OP_WRITE;
    else if (byte_in[7])    op = OP_SET_DD;
    else if (byte_in[6])    op = OP_SET_CG;
    else if (byte_in[5])    op = OP_FUNC;
    else if (byte_in[4])    op = OP_SHIFT;
    else if (byte_in[3])    op = OP_DISPCTL;
    else if (byte_in[2])    op = OP_ENTRY;
    else if (byte_in[1])    op = OP_HOME;
    else if (byte_in[0])    op = OP_CLEAR;
  end

endmodule

// File: rtl/cde_busy_timer.sv
module cde_busy_timer #(
  parameter int BUSY_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic fill_active,
  output logic busy
);

  localparam int CW = $clog2(BUSY_CYC + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= CW'(BUSY_CYC);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign busy = fill_active || (cnt != '0);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!start && !fill_active && cnt == CW'(1)) |=> (!busy || fill_active));

endmodule

// File: rtl/cde_anode_pwm.sv
module cde_anode_pwm #(
  parameter int BR_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            disp_on,
  input  logic            one_line,
  input  logic [BR_W-1:0] bright,
  output logic            anode_lo_en,
  output logic            anode_hi_en
);

  localparam int STEPS = 1 << BR_W;
  localparam int LW    = BR_W + 1;

  logic [BR_W-1:0] phase;
  logic [LW-1:0]   level;
  logic            on_now;

  // Enabled steps per period: STEPS minus the code
  assign level  = LW'(STEPS) - {1'b0, bright};
  assign on_now = disp_on && ({1'b0, phase} < level);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= '0;
      anode_lo_en <= 1'b0;
      anode_hi_en <= 1'b0;
    end else begin
      phase       <= phase + 1'b1;
      anode_lo_en <= on_now;
      anode_hi_en <= on_now && !one_line;
    end
  end

  // R11
  one_line_dark_chk: assert property (@(posedge clk) disable iff (rst)
    one_line |=> !anode_hi_en);

  // R12
  display_off_chk: assert property (@(posedge clk) disable iff (rst)
    !disp_on |=> (!anode_lo_en && !anode_hi_en));

  // R10
  full_duty_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_on && bright == '0) |=> anode_lo_en);

endmodule

// File: rtl/chardisp_cmd_engine.sv
module chardisp_cmd_engine
  import chardisp_pkg::*;
#(
  parameter int DD_AW    = 7,
  parameter int CG_AW    = 6,
  parameter int CG_DW    = 5,
  parameter int BUSY_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_rs,
  input  logic [7:0]       cmd_byte,
  output logic             busy,
  output logic [DD_AW-1:0] ac_out,
  output logic             dd_we,
  output logic [DD_AW-1:0] dd_addr,
  output logic [7:0]       dd_wdata,
  output logic             cg_we,
  output logic [CG_AW-1:0] cg_addr,
  output logic [CG_DW-1:0] cg_wdata,
  output logic             disp_on,
  output logic             cursor_on,
  output logic             blink_on,
  output logic [DD_AW-1:0] shift_ofs,
  output logic             one_line,
  output logic [1:0]       bright,
  output logic             anode_lo_en,
  output logic             anode_hi_en
);

  localparam logic [DD_AW-1:0] DD_LAST = '1;

  cde_op_e          op;
  logic             accept;
  logic [DD_AW-1:0] ac;
  logic             target_cg;
  logic             entry_inc;
  logic             entry_shift;
  logic             two_line;
  logic             fill_active;
  logic [DD_AW-1:0] fill_ptr;
  logic [DD_AW-1:0] ac_step;
  logic [CG_AW-1:0] cg_step;
  logic [DD_AW-1:0] ofs_step;

  cde_decode u_decode (
    .is_data (cmd_rs),
    .byte_in (cmd_byte),
    .op      (op)
  );

  cde_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk         (clk),
    .rst         (rst),
    .start       (accept),
    .fill_active (fill_active),
    .busy        (busy)
  );

  cde_anode_pwm #(.BR_W(2)) u_pwm (
    .clk         (clk),
    .rst         (rst),
    .disp_on     (disp_on),
    .one_line    (one_line),
    .bright      (bright),
    .anode_lo_en (anode_lo_en),
    .anode_hi_en (anode_hi_en)
  );

  assign accept   = cmd_valid && !busy;
  assign ac_step  = entry_inc ? ac + 1'b1 : ac - 1'b1;
  assign cg_step  = entry_inc ? ac[CG_AW-1:0] + 1'b1 : ac[CG_AW-1:0] - 1'b1;
  assign ofs_step = entry_inc ? shift_ofs + 1'b1 : shift_ofs - 1'b1;
  assign ac_out   = ac;
  assign one_line = !two_line;

  always_ff @(posedge clk) begin
    if (rst) begin
      ac          <= '0;
      target_cg   <= 1'b0;
      entry_inc   <= 1'b1;
      entry_shift <= 1'b0;
      disp_on     <= 1'b0;
      cursor_on   <= 1'b0;
      blink_on    <= 1'b0;
      shift_ofs   <= '0;
      two_line    <= 1'b1;
      bright      <= 2'b00;
      fill_active <= 1'b0;
      fill_ptr    <= '0;
      dd_we       <= 1'b0;
      dd_addr     <= '0;
      dd_wdata    <= '0;
      cg_we       <= 1'b0;
      cg_addr     <= '0;
      cg_wdata    <= '0;
    end else begin
      dd_we <= 1'b0;
      cg_we <= 1'b0;

      // Blank fill, one location per cycle
      if (fill_active) begin
        dd_we    <= 1'b1;
        dd_addr  <= fill_ptr;
        dd_wdata <= BLANK_CODE;
        fill_ptr <= fill_ptr + 1'b1;
        if (fill_ptr == DD_LAST) fill_active <= 1'b0;
      end

      if (accept) begin
        unique case (op)
          OP_CLEAR: begin
            fill_active <= 1'b1;
            fill_ptr    <= '0;
            ac          <= '0;
            shift_ofs   <= '0;
            entry_inc   <= 1'b1;
            target_cg   <= 1'b0;
          end
          OP_HOME: begin
            ac        <= '0;
            shift_ofs <= '0;
          end
          OP_ENTRY: begin
            entry_inc   <= cmd_byte[1];
            entry_shift <= cmd_byte[0];
          end
          OP_DISPCTL: begin
            disp_on   <= cmd_byte[2];
            cursor_on <= cmd_byte[1];
            blink_on  <= cmd_byte[0];
          end
          OP_SHIFT: begin
            unique case (cde_shift_e'(cmd_byte[3:2]))
              SH_CUR_LEFT:   ac        <= ac - 1'b1;
              SH_CUR_RIGHT:  ac        <= ac + 1'b1;
              SH_DISP_LEFT:  shift_ofs <= shift_ofs + 1'b1;
              SH_DISP_RIGHT: shift_ofs <= shift_ofs - 1'b1;
              default: ;
            endcase
          end
          OP_FUNC: begin
            two_line <= cmd_byte[3];
            bright   <= cmd_byte[1:0];
          end
          OP_SET_CG: begin
            ac        <= DD_AW'(cmd_byte[CG_AW-1:0]);
            target_cg <= 1'b1;
          end
          OP_SET_DD: begin
            ac        <= cmd_byte[DD_AW-1:0];
            target_cg <= 1'b0;
          end
          OP_WRITE: begin
            if (target_cg) begin
              cg_we    <= 1'b1;
              cg_addr  <= ac[CG_AW-1:0];
              cg_wdata <= cmd_byte[CG_DW-1:0];
              ac       <= DD_AW'(cg_step);
            end else begin
              dd_we    <= 1'b1;
              dd_addr  <= ac;
              dd_wdata <= cmd_byte;
              ac       <= ac_step;
              if (entry_shift) shift_ofs <= ofs_step;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  dd_step_up_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_WRITE && !target_cg && entry_inc) |=>
      (dd_we && dd_addr == $past(ac_out) && ac_out == $past(ac_out) + 1'b1));

  // R4
  cg_range_chk: assert property (@(posedge clk) disable iff (rst)
    cg_we |-> (ac_out < DD_AW'(1 << CG_AW)));

  // R8
  fill_blank_chk: assert property (@(posedge clk) disable iff (rst)
    fill_active |=> (dd_we && dd_wdata == BLANK_CODE && busy == $past(fill_ptr != DD_LAST)));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy && !fill_active) |=> (!dd_we && !cg_we));

  // R5
  one_ram_chk: assert property (@(posedge clk) disable iff (rst)
    !(dd_we && cg_we));

endmodule

// File: tb/test_chardisp_cmd_engine.sv
module test_chardisp_cmd_engine;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0;
  logic       cmd_rs = 1'b0;
  logic [7:0] cmd_byte = 8'h00;
  logic       busy;
  logic [6:0] ac_out;
  logic       dd_we;
  logic [6:0] dd_addr;
  logic [7:0] dd_wdata;
  logic       cg_we;
  logic [5:0] cg_addr;
  logic [4:0] cg_wdata;
  logic       disp_on, cursor_on, blink_on;
  logic [6:0] shift_ofs;
  logic       one_line;
  logic [1:0] bright;
  logic       anode_lo_en, anode_hi_en;

  int checks = 0;
  int errors = 0;
  int dd_writes = 0;
  int cg_writes = 0;
  bit done = 0;

  logic [7:0] ddm [128];
  logic [4:0] cgm [64];

  always #10 clk = ~clk;

  chardisp_cmd_engine i_chardisp_cmd_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_rs(cmd_rs),
    .cmd_byte(cmd_byte), .busy(busy), .ac_out(ac_out), .dd_we(dd_we),
    .dd_addr(dd_addr), .dd_wdata(dd_wdata), .cg_we(cg_we),
    .cg_addr(cg_addr), .cg_wdata(cg_wdata), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .shift_ofs(shift_ofs),
    .one_line(one_line), .bright(bright), .anode_lo_en(anode_lo_en),
    .anode_hi_en(anode_hi_en)
  );

  // RAM models built from the write strobes
  always @(negedge clk) begin
    if (!rst && dd_we) begin ddm[dd_addr] <= dd_wdata; dd_writes++; end
    if (!rst && cg_we) begin cgm[cg_addr] <= cg_wdata; cg_writes++; end
  end

  // {rs, byte, expected address counter}
  localparam logic [15:0] VEC [0:15] = '{
    {1'b0, 8'h06, 7'h00},  // R2 entry increment
    {1'b1, 8'h41, 7'h01},  // R3
    {1'b1, 8'h42, 7'h02},  // R3
    {1'b0, 8'h85, 7'h05},  // R5 set DD
    {1'b0, 8'h04, 7'h05},  // R2 entry decrement
    {1'b1, 8'h43, 7'h04},  // R3
    {1'b1, 8'h44, 7'h03},  // R3
    {1'b0, 8'h10, 7'h02},  // R6 cursor left
    {1'b0, 8'h14, 7'h03},  // R6 cursor right
    {1'b0, 8'h80, 7'h00},  // R5
    {1'b1, 8'h45, 7'h7F},  // R3 wrap down
    {1'b0, 8'h48, 7'h08},  // R5 set CG
    {1'b0, 8'h06, 7'h08},  // R2
    {1'b1, 8'hFF, 7'h09},  // R4
    {1'b0, 8'h7F, 7'h3F},  // R5
    {1'b1, 8'h0A, 7'h00}   // R4 wrap at 64
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic rs, input logic [7:0] b);
    while (busy) @(negedge clk);
    cmd_rs = rs; cmd_byte = b; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic duty(output int lo, output int hi);
    repeat (3) @(negedge clk);
    lo = 0; hi = 0;
    for (int k = 0; k < 8; k++) begin
      lo += int'(anode_lo_en); hi += int'(anode_hi_en);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, lo, hi, base, bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 ac", ac_out, 0);
    check("R1 shift", shift_ofs, 0);
    check("R1 display", {disp_on, cursor_on, blink_on}, 0);
    check("R1 lines/bright", {one_line, bright}, 0);
    check("R1 strobes/anodes", {dd_we, cg_we, anode_lo_en, anode_hi_en}, 0);

    for (int i = 0; i < 16; i++) begin
      send(VEC[i][15], VEC[i][14:7]);
      check($sformatf("R3/R4/R5/R6 vector %0d ac", i), ac_out, VEC[i][6:0]);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R3 dd[0]", ddm[0], 8'h45);
    check("R3 dd[1]", ddm[1], 8'h42);
    check("R3 dd[4]", ddm[4], 8'h44);
    check("R3 dd[5]", ddm[5], 8'h43);
    check("R4 cg[08]", cgm[8], 5'h1F);
    check("R4 cg[3F]", cgm[63], 5'h0A);
    check("R5 counts", dd_writes * 100 + cg_writes, 5 * 100 + 2);

    // R7 auto shift, R6 display shift
    send(0, 8'h07); send(0, 8'h90);
    send(1, 8'h5A);
    check("R7 inc shift", shift_ofs, 1);
    check("R7 ac", ac_out, 7'h11);
    send(0, 8'h18);
    check("R6 display left", {shift_ofs, ac_out}, {7'd2, 7'h11});
    send(0, 8'h1C);
    check("R6 display right", {shift_ofs, ac_out}, {7'd1, 7'h11});
    send(0, 8'h05); send(1, 8'h5B);
    check("R7 dec shift", {shift_ofs, ac_out}, {7'd0, 7'h10});
    send(0, 8'h18); send(0, 8'h02);
    check("R13 home", {shift_ofs, ac_out}, 0);
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R13 ram kept", {ddm[16], ddm[17]}, {8'h5A, 8'h5B});

    // R9 ignored while busy
    send(0, 8'h06); send(0, 8'h83);
    while (busy) @(negedge clk);
    base = dd_writes;
    cmd_rs = 1; cmd_byte = 8'h66; cmd_valid = 1;
    @(negedge clk);
    cmd_rs = 0; cmd_byte = 8'h8F;
    repeat (2) @(negedge clk);
    cmd_valid = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check("R9 ignored ac", ac_out, 4);
    check("R9 one write", dd_writes - base, 1);
    check("R9 data", ddm[3], 8'h66);
    send(0, 8'h0F);
    check("R2 display ctl", {disp_on, cursor_on, blink_on}, 3'b111);
    busy_len(n);
    check("R9 busy length", n, 4);

    // R10 / R11 / R12 brightness
    send(0, 8'h38); duty(lo, hi);
    check("R10 br00", lo * 100 + hi, 8 * 100 + 8);
    send(0, 8'h39); duty(lo, hi);
    check("R10 br01", lo * 100 + hi, 6 * 100 + 6);
    send(0, 8'h3A); duty(lo, hi);
    check("R10 br10", lo, 4);
    send(0, 8'h3B); duty(lo, hi);
    check("R10 br11", lo, 2);
    send(0, 8'h30); duty(lo, hi);
    check("R11 one line", {one_line, 7'(lo), 7'(hi)}, {1'b1, 7'd8, 7'd0});
    send(0, 8'h08); duty(lo, hi);
    check("R12 display off", lo + hi, 0);

    // R8 clear
    send(0, 8'h04); send(0, 8'h18);
    base = dd_writes;
    send(0, 8'h01);
    busy_len(n);
    check("R8 busy length", n, 128);
    @(negedge clk);
    check("R8 writes", dd_writes - base, 128);
    check("R8 ac/shift", {ac_out, shift_ofs}, 0);
    bad = 0;
    for (int a = 0; a < 128; a++) if (ddm[a] !== 8'h20) bad++;
    check("R8 blanks", bad, 0);
    send(1, 8'h31);
    check("R8 increment", ac_out, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule